// File: doc/BRIEF.md
# Capture/Compare Timer Channel with Shadowed Compare Value

This block is one channel of a general-purpose timer. It owns a single 16-bit data register that has two jobs, and the job depends on the channel mode. In capture (input) mode the register takes a snapshot of the free-running counter whenever a qualified channel event arrives. Each capture also raises a capture flag. A second capture taken while that flag is still up raises an overcapture flag as well. In compare (output) mode the register is the threshold for a PWM-style output: the output is high while the counter is below the active compare value.

Software writes the register through a simple bus write strobe and reads it back on a read-data port. A buffer-enable input selects the write behaviour in compare mode. With buffering off, a write takes effect on the next clock. With buffering on, the write lands in a shadow (preload) register and is copied into the active register only on the counter update event, which keeps PWM periods glitch-free. The counter and the update event come from outside the block.

The capture flags are kept by a small state machine. Its states are `FL_EMPTY` (no unread capture), `FL_HELD` (one capture pending) and `FL_OVER` (a capture was overwritten). Its transitions are:
- capture: `FL_EMPTY`→`FL_HELD`, `FL_HELD`→`FL_OVER`, `FL_OVER`→`FL_OVER`;
- clear: any state→`FL_EMPTY`;
- clear and capture in the same cycle: any state→`FL_HELD`.

Top module: `ccc_top`

## Requirements
- R1: After reset the read data is 0x0000, both flags are 0, and in compare mode the output is 0 for every counter value.
- R2: In capture mode (`mode_in_i`=1), an `evt_i` pulse makes `rd_data_o` equal the counter value of that cycle from the next clock on.
- R3: In capture mode a bus write never changes `rd_data_o`. When a write and an event fall in the same cycle, the captured counter value wins.
- R4: In compare mode with `buf_en_i`=0, a write makes `rd_data_o` equal the written data from the next clock on.
- R5: In compare mode with `buf_en_i`=1, a write leaves `rd_data_o` unchanged until a cycle with `upd_i`=1. After that clock, `rd_data_o` equals the preload value held before that edge, so a write in the same cycle as the update waits for the next update.
- R6: In compare mode, `out_o` is 1 exactly when `cnt_i` is less than `rd_data_o` (unsigned). It follows `cnt_i` with no clock delay.
- R7: In capture mode `out_o` is 0.
- R8: A capture moves the flags from (cap=0, over=0) to (1,0), and from (1,0) or (1,1) to (1,1). The overcapture flag is never 1 while the capture flag is 0.
- R9: `flag_clr_i` clears both flags on the next clock. If a capture coincides with it, the result is cap=1 and over=0.
- R10: In compare mode `evt_i` changes neither `rd_data_o` nor the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_i | input | 16 | Running counter value |
| upd_i | input | 1 | Counter overflow/update event, one cycle |
| mode_in_i | input | 1 | 1 = capture mode, 0 = compare mode |
| buf_en_i | input | 1 | 1 = compare writes go through preload |
| evt_i | input | 1 | Qualified channel input event, one cycle |
| wr_en_i | input | 1 | Bus write strobe |
| wr_data_i | input | 16 | Bus write data |
| flag_clr_i | input | 1 | Clear capture and overcapture flags |
| rd_data_o | output | 16 | Active data register |
| out_o | output | 1 | Channel compare output |
| cap_flag_o | output | 1 | Capture flag |
| ovcap_flag_o | output | 1 | Overcapture flag |

## Verification
Two pairs of functions can act in the same clock cycle, and the bench drives each pair together on purpose. The first pair is a bus write and a capture event in capture mode. That cycle is judged by reading back the counter value of the event cycle and not the write data. The second pair is a flag clear and a capture. The expected outcome there is the single-capture flag state. A related case, a buffered write in the same cycle as the update event, is checked by expecting the old preload value to become active first and the new one only at the following update.

// File: rtl/ccc_pkg.sv
`timescale 1ns/1ps
package ccc_pkg;
    typedef enum logic [1:0] {
        FL_EMPTY = 2'd0,
        FL_HELD  = 2'd1,
        FL_OVER  = 2'd2
    } flag_st_e;
endpackage

// File: rtl/ccc_flagfsm.sv
`timescale 1ns/1ps
module ccc_flagfsm
    import ccc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cap_evt_i,
    input  logic clr_i,
    output logic cap_o,
    output logic over_o
);
    flag_st_e st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (clr_i) begin
            st_d = cap_evt_i ? FL_HELD : FL_EMPTY;
        end else if (cap_evt_i) begin
            unique case (st_q)
                FL_EMPTY: st_d = FL_HELD;
                FL_HELD:  st_d = FL_OVER;
                FL_OVER:  st_d = FL_OVER;
                default:  st_d = FL_EMPTY;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= FL_EMPTY;
        else        st_q <= st_d;
    end

    always_comb begin
        cap_o  = 1'b0;
        over_o = 1'b0;
        unique case (st_q)
            FL_EMPTY: begin cap_o = 1'b0; over_o = 1'b0; end
            FL_HELD:  begin cap_o = 1'b1; over_o = 1'b0; end
            FL_OVER:  begin cap_o = 1'b1; over_o = 1'b1; end
            default:  begin cap_o = 1'b0; over_o = 1'b0; end
        endcase
    end
endmodule

// File: rtl/ccc_datareg.sv
`timescale 1ns/1ps
module ccc_datareg #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mode_in_i,
    input  logic          buf_en_i,
    input  logic          upd_i,
    input  logic          evt_i,
    input  logic [DW-1:0] cnt_i,
    input  logic          wr_en_i,
    input  logic [DW-1:0] wr_data_i,
    output logic [DW-1:0] act_o
);
    logic [DW-1:0] act_q, pre_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q <= '0;
            pre_q <= '0;
        end else if (mode_in_i) begin
            // capture mode: the counter snapshot is the only writer
            if (evt_i) act_q <= cnt_i;
        end else begin
            if (wr_en_i) pre_q <= wr_data_i;
            if (wr_en_i && !buf_en_i)  act_q <= wr_data_i;
            else if (upd_i && buf_en_i) act_q <= pre_q;
        end
    end

    assign act_o = act_q;
endmodule

// File: rtl/ccc_cmpout.sv
`timescale 1ns/1ps
module ccc_cmpout #(
    parameter int DW = 16
) (
    input  logic          mode_in_i,
    input  logic [DW-1:0] cnt_i,
    input  logic [DW-1:0] thr_i,
    output logic          out_o
);
    always_comb begin
        out_o = 1'b0;
        if (!mode_in_i) out_o = (cnt_i < thr_i);
    end
endmodule

// File: rtl/ccc_top.sv
`timescale 1ns/1ps
module ccc_top #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] cnt_i,
    input  logic          upd_i,
    input  logic          mode_in_i,
    input  logic          buf_en_i,
    input  logic          evt_i,
    input  logic          wr_en_i,
    input  logic [DW-1:0] wr_data_i,
    input  logic          flag_clr_i,
    output logic [DW-1:0] rd_data_o,
    output logic          out_o,
    output logic          cap_flag_o,
    output logic          ovcap_flag_o
);
    logic cap_evt;
    assign cap_evt = mode_in_i & evt_i;

    ccc_datareg #(.DW(DW)) u_reg (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_in_i (mode_in_i),
        .buf_en_i  (buf_en_i),
        .upd_i     (upd_i),
        .evt_i     (evt_i),
        .cnt_i     (cnt_i),
        .wr_en_i   (wr_en_i),
        .wr_data_i (wr_data_i),
        .act_o     (rd_data_o)
    );

    ccc_cmpout #(.DW(DW)) u_cmp (
        .mode_in_i (mode_in_i),
        .cnt_i     (cnt_i),
        .thr_i     (rd_data_o),
        .out_o     (out_o)
    );

    ccc_flagfsm u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .cap_evt_i (cap_evt),
        .clr_i     (flag_clr_i),
        .cap_o     (cap_flag_o),
        .over_o    (ovcap_flag_o)
    );
endmodule

// File: rtl/ccc_chk.sv
`timescale 1ns/1ps
module ccc_chk #(
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic [DW-1:0] cnt_i,
    input logic          upd_i,
    input logic          mode_in_i,
    input logic          buf_en_i,
    input logic          evt_i,
    input logic          wr_en_i,
    input logic [DW-1:0] wr_data_i,
    input logic          flag_clr_i,
    input logic [DW-1:0] rd_data_o,
    input logic          out_o,
    input logic          cap_flag_o,
    input logic          ovcap_flag_o
);
    p_cap_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mode_in_i && evt_i |=> rd_data_o == $past(cnt_i));

    p_wr_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mode_in_i && !evt_i |=> $stable(rd_data_o));

    p_direct_wr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_in_i && wr_en_i && !buf_en_i |=> rd_data_o == $past(wr_data_i));

    p_buf_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_in_i && buf_en_i && !upd_i |=> $stable(rd_data_o));

    p_out_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mode_in_i |-> !out_o);

    p_over_needs_cap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ovcap_flag_o |-> cap_flag_o);

    p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        flag_clr_i && !(mode_in_i && evt_i) |=> !cap_flag_o && !ovcap_flag_o);

    p_evt_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_in_i && evt_i && !flag_clr_i |=> $stable(cap_flag_o) && $stable(ovcap_flag_o));
endmodule

bind ccc_top ccc_chk #(.DW(DW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cnt_i        (cnt_i),
    .upd_i        (upd_i),
    .mode_in_i    (mode_in_i),
    .buf_en_i     (buf_en_i),
    .evt_i        (evt_i),
    .wr_en_i      (wr_en_i),
    .wr_data_i    (wr_data_i),
    .flag_clr_i   (flag_clr_i),
    .rd_data_o    (rd_data_o),
    .out_o        (out_o),
    .cap_flag_o   (cap_flag_o),
    .ovcap_flag_o (ovcap_flag_o)
);

// File: tb/tb_ccc_top.sv
`timescale 1ns/1ps
module tb_ccc_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [15:0] cnt_i;
    logic        upd_i, mode_in_i, buf_en_i, evt_i, wr_en_i, flag_clr_i;
    logic [15:0] wr_data_i;
    logic [15:0] rd_data_o;
    logic        out_o, cap_flag_o, ovcap_flag_o;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    ccc_top dut (
        .clk(clk), .rst_n(rst_n), .cnt_i(cnt_i), .upd_i(upd_i),
        .mode_in_i(mode_in_i), .buf_en_i(buf_en_i), .evt_i(evt_i),
        .wr_en_i(wr_en_i), .wr_data_i(wr_data_i), .flag_clr_i(flag_clr_i),
        .rd_data_o(rd_data_o), .out_o(out_o), .cap_flag_o(cap_flag_o),
        .ovcap_flag_o(ovcap_flag_o)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got=0x%0h expected=0x%0h", req, got, exp);
        end
    endtask

    // drive pulses at a falling edge, release them at the next falling edge
    task automatic step(input logic wr, input logic [15:0] wd, input logic ev,
                        input logic up, input logic clr);
        @(negedge clk);
        wr_en_i = wr; wr_data_i = wd; evt_i = ev; upd_i = up; flag_clr_i = clr;
        @(negedge clk);
        wr_en_i = 0; evt_i = 0; upd_i = 0; flag_clr_i = 0;
    endtask

    task automatic sweep_out(input logic [15:0] thr);
        for (int c = 0; c < 300; c++) begin
            cnt_i = 16'(c); #1;
            chk("R6 sweep", {31'd0, out_o}, {31'd0, (16'(c) < thr)});
        end
        for (int d = -1; d <= 1; d++) begin
            cnt_i = thr + 16'(d); #1;
            chk("R6 edge", {31'd0, out_o}, {31'd0, ((thr + 16'(d)) < thr)});
        end
        cnt_i = 16'hFFFF; #1;
        chk("R6 top", {31'd0, out_o}, {31'd0, (16'hFFFF < thr)});
    endtask

    initial begin
        logic [15:0] thr_list [6];
        logic [15:0] prev, c;
        thr_list = '{16'h0000, 16'h0001, 16'h0080, 16'h00FF, 16'h012B, 16'hFFFF};
        rst_n = 0; cnt_i = 0; upd_i = 0; mode_in_i = 0; buf_en_i = 0;
        evt_i = 0; wr_en_i = 0; wr_data_i = 0; flag_clr_i = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R1 reset state
        chk("R1 rd", {16'd0, rd_data_o}, 32'h0);
        chk("R1 cap", {31'd0, cap_flag_o}, 32'h0);
        chk("R1 over", {31'd0, ovcap_flag_o}, 32'h0);
        for (int k = 0; k < 4; k++) begin
            cnt_i = 16'(k * 16'h3FFF); #1;
            chk("R1 out", {31'd0, out_o}, 32'h0);
        end

        // R4 direct writes, R6 compare sweeps
        foreach (thr_list[i]) begin
            step(1, thr_list[i], 0, 0, 0);
            chk("R4 direct write", {16'd0, rd_data_o}, {16'd0, thr_list[i]});
            sweep_out(thr_list[i]);
        end

        // R5 buffered writes
        buf_en_i = 1;
        prev = rd_data_o;
        step(1, 16'hAAAA, 0, 0, 0);
        chk("R5 held", {16'd0, rd_data_o}, {16'd0, prev});
        step(0, 0, 0, 0, 0);
        chk("R5 still held", {16'd0, rd_data_o}, {16'd0, prev});
        step(0, 0, 0, 1, 0);
        chk("R5 after update", {16'd0, rd_data_o}, 32'hAAAA);
        step(1, 16'h5555, 0, 1, 0);
        chk("R5 write+update same cycle", {16'd0, rd_data_o}, 32'hAAAA);
        step(0, 0, 0, 1, 0);
        chk("R5 second update", {16'd0, rd_data_o}, 32'h5555);
        buf_en_i = 0;

        // R10 event in compare mode
        cnt_i = 16'h0042;
        step(0, 0, 1, 0, 0);
        chk("R10 rd", {16'd0, rd_data_o}, 32'h5555);
        chk("R10 cap", {31'd0, cap_flag_o}, 32'h0);
        chk("R10 over", {31'd0, ovcap_flag_o}, 32'h0);

        // R7 capture mode forces output low
        mode_in_i = 1; cnt_i = 0; #1;
        chk("R7 out", {31'd0, out_o}, 32'h0);

        // R2 captures and R8 flag sequencing
        for (int k = 0; k < 24; k++) begin
            c = 16'(k * 2731 + 3);
            cnt_i = c;
            step(0, 0, 1, 0, 0);
            cnt_i = ~c;
            chk("R2 capture", {16'd0, rd_data_o}, {16'd0, c});
            chk("R8 cap", {31'd0, cap_flag_o}, 32'h1);
            chk("R8 over", {31'd0, ovcap_flag_o}, {31'd0, (k > 0)});
            #1 chk("R7 out during capture", {31'd0, out_o}, 32'h0);
        end

        // R9 clear alone, then clear with capture
        step(0, 0, 0, 0, 1);
        chk("R9 clear cap", {31'd0, cap_flag_o}, 32'h0);
        chk("R9 clear over", {31'd0, ovcap_flag_o}, 32'h0);
        step(0, 0, 1, 0, 0);
        step(0, 0, 1, 0, 0);
        cnt_i = 16'h1357;
        step(0, 0, 1, 0, 1);
        chk("R9 clear+capture cap", {31'd0, cap_flag_o}, 32'h1);
        chk("R9 clear+capture over", {31'd0, ovcap_flag_o}, 32'h0);

        // R3 writes ignored in capture mode
        prev = rd_data_o;
        step(1, 16'hBEEF, 0, 0, 0);
        chk("R3 write ignored", {16'd0, rd_data_o}, {16'd0, prev});
        step(1, 16'hBEEF, 0, 1, 0);
        chk("R3 write+update ignored", {16'd0, rd_data_o}, {16'd0, prev});
        cnt_i = 16'h2468;
        step(1, 16'hBEEF, 1, 0, 0);
        chk("R3 capture beats write", {16'd0, rd_data_o}, 32'h2468);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: got=timeout expected=completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule